// File: doc/BRIEF.md
# Digital Ramp Generator Accumulator

This block produces a stepped ramp for the control path of a frequency synthesizer. An accumulator moves between a lower and an upper bound. Upward and downward travel each have their own increment and their own tick spacing. A direction input picks the way the ramp moves, and a pause input freezes it in place. The ramp value replaces one of three control words: frequency, phase or amplitude. The other two words pass through unchanged. A finished flag shows that the last step reached the bound the ramp is heading for.

All settings arrive on shadow inputs and are copied into an active set only when the update strobe is high. An update strobe or a change on the profile-select input raises an internal event one cycle later. This event can clear the accumulator once and can restart the tick spacing. A held-clear setting keeps the accumulator at zero for as long as it stays active. Either bound can be set to no-dwell. The ramp then jumps to the opposite bound instead of resting on the one it reached.

Top module: `ramp_gen_top`

## Requirements
- R1: Shadow setting inputs have no effect until the update strobe is high at a clock edge. The settings copied at that edge drive the ramp from the next cycle on.
- R2: While the direction input is 1 (up), each tick adds the rising increment. A result at or above the upper bound is clamped to the upper bound and never wraps.
- R3: While the direction input is 0 (down), each tick subtracts the falling increment. A result at or below the lower bound is clamped to the lower bound.
- R4: The rising interval N (or the falling interval, going down) makes one tick every N cycles. An interval of 0 acts as 1.
- R5: While pause is high, the accumulator and the interval counter hold their values. The ramp resumes from the same point when pause falls.
- R6: With no-dwell-high active, an upward tick that reaches the upper bound loads the lower bound instead.
- R7: With no-dwell-low active, a downward tick that reaches the lower bound loads the upper bound instead.
- R8: While the active held-clear bit is set, the accumulator reads zero and the finished flag reads 0.
- R9: With auto-clear active, an update strobe or a change on the profile select zeroes the accumulator once, one cycle after the event. Ramping then resumes.
- R10: With load-rate active, the same event restarts the interval counter at its full spacing.
- R11: The finished flag is registered. Each tick sets it when that tick reached its bound in the current direction, and clears it otherwise. It changes only on ticks and clears.
- R12: Destination code 0 routes the ramp to the frequency output, 1 to the phase output and 2 to the amplitude output. Code 3 routes it nowhere. Every output that is not selected equals its base input.
- R13: During reset the ramp and the finished flag are 0, all active settings are 0 and the destination code is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | Update strobe: copies shadow settings to active set |
| prof_i | input | PROF_W | Profile select; any change raises an event |
| dir_up_i | input | 1 | 1 ramps up, 0 ramps down |
| pause_i | input | 1 | Freezes accumulator and interval counter |
| sh_lo_i | input | ACC_W | Shadow lower bound |
| sh_hi_i | input | ACC_W | Shadow upper bound (must exceed lower) |
| sh_rise_step_i | input | ACC_W | Shadow rising increment |
| sh_fall_step_i | input | ACC_W | Shadow falling increment |
| sh_rise_ival_i | input | INT_W | Shadow rising tick spacing in cycles |
| sh_fall_ival_i | input | INT_W | Shadow falling tick spacing in cycles |
| sh_dest_i | input | 2 | Shadow destination code |
| sh_nodwell_hi_i | input | 1 | Shadow no-dwell at upper bound |
| sh_nodwell_lo_i | input | 1 | Shadow no-dwell at lower bound |
| sh_autoclr_i | input | 1 | Shadow one-shot clear on event |
| sh_holdclr_i | input | 1 | Shadow held clear |
| sh_ldrate_i | input | 1 | Shadow interval restart on event |
| freq_base_i | input | ACC_W | Frequency word when not overridden |
| phase_base_i | input | ACC_W | Phase word when not overridden |
| amp_base_i | input | ACC_W | Amplitude word when not overridden |
| freq_o | output | ACC_W | Frequency word out |
| phase_o | output | ACC_W | Phase word out |
| amp_o | output | ACC_W | Amplitude word out |
| ramp_o | output | ACC_W | Raw accumulator value |
| done_o | output | 1 | Ramp-finished flag |

## Verification
The bench targets several corner cases:
- Steps that land on a bound exactly, and steps that would overshoot it. A design that wraps or misses the clamp would show a value outside the bounds.
- No-dwell jumps at each bound. If they are wrong, the ramp would sit on the bound or jump to the wrong one.
- Intervals of 0 and 1, and direction changes between ticks. A design that counts spacing wrongly or uses the wrong direction's interval would step in the wrong cycles.
- The one-cycle-late event on a profile change alone, and pause arriving while a reload is pending. A design that applies an event late or lets shadow values leak through would diverge from the cycle model.

// File: rtl/drg_pkg.sv
// Shared definitions for the ramp generator.
// Assumes: destination code is two bits wide; code 3 means no override.
package drg_pkg;
    typedef enum logic [1:0] {
        DEST_FREQ  = 2'd0,
        DEST_PHASE = 2'd1,
        DEST_AMP   = 2'd2,
        DEST_NONE  = 2'd3
    } dest_e;
endpackage

// File: rtl/drg_cfg_bank.sv
// Active setting bank and event detector.
// The shadow inputs are copied to the active set only on the update strobe.
// An update strobe or a change on the profile select raises evt_o one cycle later.
// Assumes: the shadow inputs are stable in the cycle the strobe is high.
module drg_cfg_bank #(
    parameter int ACC_W  = 16,
    parameter int INT_W  = 8,
    parameter int PROF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [PROF_W-1:0] prof_i,
    input  logic [ACC_W-1:0]  sh_lo_i,
    input  logic [ACC_W-1:0]  sh_hi_i,
    input  logic [ACC_W-1:0]  sh_rise_step_i,
    input  logic [ACC_W-1:0]  sh_fall_step_i,
    input  logic [INT_W-1:0]  sh_rise_ival_i,
    input  logic [INT_W-1:0]  sh_fall_ival_i,
    input  logic [1:0]        sh_dest_i,
    input  logic              sh_nodwell_hi_i,
    input  logic              sh_nodwell_lo_i,
    input  logic              sh_autoclr_i,
    input  logic              sh_holdclr_i,
    input  logic              sh_ldrate_i,
    output logic [ACC_W-1:0]  lo_o,
    output logic [ACC_W-1:0]  hi_o,
    output logic [ACC_W-1:0]  rise_step_o,
    output logic [ACC_W-1:0]  fall_step_o,
    output logic [INT_W-1:0]  rise_ival_o,
    output logic [INT_W-1:0]  fall_ival_o,
    output drg_pkg::dest_e    dest_o,
    output logic              nodwell_hi_o,
    output logic              nodwell_lo_o,
    output logic              autoclr_o,
    output logic              holdclr_o,
    output logic              ldrate_o,
    output logic              evt_o
);
    logic [PROF_W-1:0] prof_q;

    // Copy the shadow settings into the active set on the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_o         <= '0;
            hi_o         <= '0;
            rise_step_o  <= '0;
            fall_step_o  <= '0;
            rise_ival_o  <= '0;
            fall_ival_o  <= '0;
            dest_o       <= drg_pkg::DEST_NONE;
            nodwell_hi_o <= 1'b0;
            nodwell_lo_o <= 1'b0;
            autoclr_o    <= 1'b0;
            holdclr_o    <= 1'b0;
            ldrate_o     <= 1'b0;
        end else if (upd_i) begin
            lo_o         <= sh_lo_i;
            hi_o         <= sh_hi_i;
            rise_step_o  <= sh_rise_step_i;
            fall_step_o  <= sh_fall_step_i;
            rise_ival_o  <= sh_rise_ival_i;
            fall_ival_o  <= sh_fall_ival_i;
            dest_o       <= drg_pkg::dest_e'(sh_dest_i);
            nodwell_hi_o <= sh_nodwell_hi_i;
            nodwell_lo_o <= sh_nodwell_lo_i;
            autoclr_o    <= sh_autoclr_i;
            holdclr_o    <= sh_holdclr_i;
            ldrate_o     <= sh_ldrate_i;
        end
    end

    // Register the event raised by an update strobe or a profile change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prof_q <= '0;
            evt_o  <= 1'b0;
        end else begin
            prof_q <= prof_i;
            evt_o  <= upd_i || (prof_i != prof_q);
        end
    end

    // R1: without a strobe the active bounds and increments do not move.
    assert_shadow_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> ($stable(lo_o) && $stable(hi_o) && $stable(rise_step_o) &&
                    $stable(fall_step_o) && $stable(holdclr_o) && $stable(dest_o)));
endmodule

// File: rtl/drg_interval.sv
// Tick generator that spaces the ramp steps.
// It counts down from (interval - 1) and fires when the count is zero.
// The direction input picks the rising or the falling interval; 0 acts as 1.
// Assumes: reload_i is a single-cycle pulse from the event logic.
module drg_interval #(
    parameter int INT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INT_W-1:0] rise_ival_i,
    input  logic [INT_W-1:0] fall_ival_i,
    input  logic             dir_up_i,
    input  logic             pause_i,
    input  logic             reload_i,
    output logic             tick_o
);
    logic [INT_W-1:0] cnt_q;
    logic [INT_W-1:0] ival_sel;
    logic [INT_W-1:0] reload_val;

    // Pick the spacing for the current direction and form the reload count.
    always_comb begin
        ival_sel   = dir_up_i ? rise_ival_i : fall_ival_i;
        reload_val = (ival_sel == '0) ? '0 : ival_sel - 1'b1;
        tick_o     = !reload_i && !pause_i && (cnt_q == '0);
    end

    // Count down to the next tick; a forced reload or pause takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload_i) begin
            cnt_q <= reload_val;
        end else if (pause_i) begin
            cnt_q <= cnt_q;
        end else if (cnt_q == '0) begin
            cnt_q <= reload_val;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R5: pause without a reload leaves the counter untouched.
    assert_pause_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_i && !reload_i) |=> $stable(cnt_q));

    // R4: with a spacing above one, two ticks never fall in adjacent cycles.
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && reload_val != '0) |=> !tick_o);
endmodule

// File: rtl/drg_stepper.sv
// Ramp accumulator with clamping at both bounds and optional no-dwell jumps.
// A clear forces zero; otherwise the value moves one step per tick.
// Assumes: lo_i < hi_i; the sums use one guard bit, so they never wrap.
module drg_stepper #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] lo_i,
    input  logic [ACC_W-1:0] hi_i,
    input  logic [ACC_W-1:0] rise_step_i,
    input  logic [ACC_W-1:0] fall_step_i,
    input  logic             nodwell_hi_i,
    input  logic             nodwell_lo_i,
    input  logic             dir_up_i,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             done_o
);
    localparam int SUM_W = ACC_W + 1;

    logic [SUM_W-1:0] up_sum;
    logic [SUM_W-1:0] dn_floor;
    logic             up_hit;
    logic             dn_hit;
    logic [ACC_W-1:0] acc_next;
    logic             hit_next;

    // Compute the next value with one guard bit and decide whether a bound is reached.
    always_comb begin
        up_sum   = {1'b0, acc_o} + {1'b0, rise_step_i};
        dn_floor = {1'b0, lo_i} + {1'b0, fall_step_i};
        up_hit   = up_sum >= {1'b0, hi_i};
        dn_hit   = {1'b0, acc_o} <= dn_floor;
        if (dir_up_i) begin
            hit_next = up_hit;
            if (!up_hit)          acc_next = up_sum[ACC_W-1:0];
            else if (nodwell_hi_i) acc_next = lo_i;
            else                  acc_next = hi_i;
        end else begin
            hit_next = dn_hit;
            if (!dn_hit)          acc_next = acc_o - fall_step_i;
            else if (nodwell_lo_i) acc_next = hi_i;
            else                  acc_next = lo_i;
        end
    end

    // Update the accumulator and the finished flag on clears and ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc_o  <= '0;
            done_o <= 1'b0;
        end else if (tick_i) begin
            acc_o  <= acc_next;
            done_o <= hit_next;
        end
    end

    // R2: an upward step never leaves a value above the bound it saw.
    assert_clamp_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && dir_up_i && !clr_i) |=> (acc_o <= $past(hi_i)));

    // R3: a downward step never leaves a value below the bound it saw.
    assert_clamp_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !dir_up_i && !clr_i) |=> (acc_o >= $past(lo_i)));

    // R8: a clear always yields zero in the next cycle.
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0 && !done_o));

    // R5: without a tick or clear the accumulator holds.
    assert_acc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> ($stable(acc_o) && $stable(done_o)));

    // R11: the finished flag only rises as the result of a tick.
    assert_done_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(tick_i));
endmodule

// File: rtl/drg_router.sv
// Destination selector: the ramp replaces exactly one control word, or none.
// Assumes: the destination code is already registered in the active bank.
module drg_router #(
    parameter int ACC_W = 16
) (
    input  drg_pkg::dest_e   dest_i,
    input  logic [ACC_W-1:0] ramp_i,
    input  logic [ACC_W-1:0] freq_base_i,
    input  logic [ACC_W-1:0] phase_base_i,
    input  logic [ACC_W-1:0] amp_base_i,
    output logic [ACC_W-1:0] freq_o,
    output logic [ACC_W-1:0] phase_o,
    output logic [ACC_W-1:0] amp_o
);
    // Replace the selected word and pass the others through.
    always_comb begin
        freq_o  = (dest_i == drg_pkg::DEST_FREQ)  ? ramp_i : freq_base_i;
        phase_o = (dest_i == drg_pkg::DEST_PHASE) ? ramp_i : phase_base_i;
        amp_o   = (dest_i == drg_pkg::DEST_AMP)   ? ramp_i : amp_base_i;
    end
endmodule

// File: rtl/ramp_gen_top.sv
// Top of the ramp generator: active bank, tick generator, accumulator and router.
// Event effects (one-shot clear, interval restart) use the active settings
// one cycle after the strobe or profile change.
// Assumes: the active lower bound is below the active upper bound.
module ramp_gen_top #(
    parameter int ACC_W  = 16,
    parameter int INT_W  = 8,
    parameter int PROF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [PROF_W-1:0] prof_i,
    input  logic              dir_up_i,
    input  logic              pause_i,
    input  logic [ACC_W-1:0]  sh_lo_i,
    input  logic [ACC_W-1:0]  sh_hi_i,
    input  logic [ACC_W-1:0]  sh_rise_step_i,
    input  logic [ACC_W-1:0]  sh_fall_step_i,
    input  logic [INT_W-1:0]  sh_rise_ival_i,
    input  logic [INT_W-1:0]  sh_fall_ival_i,
    input  logic [1:0]        sh_dest_i,
    input  logic              sh_nodwell_hi_i,
    input  logic              sh_nodwell_lo_i,
    input  logic              sh_autoclr_i,
    input  logic              sh_holdclr_i,
    input  logic              sh_ldrate_i,
    input  logic [ACC_W-1:0]  freq_base_i,
    input  logic [ACC_W-1:0]  phase_base_i,
    input  logic [ACC_W-1:0]  amp_base_i,
    output logic [ACC_W-1:0]  freq_o,
    output logic [ACC_W-1:0]  phase_o,
    output logic [ACC_W-1:0]  amp_o,
    output logic [ACC_W-1:0]  ramp_o,
    output logic              done_o
);
    logic [ACC_W-1:0] a_lo, a_hi, a_rstep, a_fstep;
    logic [INT_W-1:0] a_rival, a_fival;
    drg_pkg::dest_e   a_dest;
    logic             a_ndhi, a_ndlo, a_auto, a_hold, a_ldr;
    logic             evt;
    logic             tick;
    logic             clr;
    logic             reload;

    drg_cfg_bank #(.ACC_W(ACC_W), .INT_W(INT_W), .PROF_W(PROF_W)) cfg_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .upd_i           (upd_i),
        .prof_i          (prof_i),
        .sh_lo_i         (sh_lo_i),
        .sh_hi_i         (sh_hi_i),
        .sh_rise_step_i  (sh_rise_step_i),
        .sh_fall_step_i  (sh_fall_step_i),
        .sh_rise_ival_i  (sh_rise_ival_i),
        .sh_fall_ival_i  (sh_fall_ival_i),
        .sh_dest_i       (sh_dest_i),
        .sh_nodwell_hi_i (sh_nodwell_hi_i),
        .sh_nodwell_lo_i (sh_nodwell_lo_i),
        .sh_autoclr_i    (sh_autoclr_i),
        .sh_holdclr_i    (sh_holdclr_i),
        .sh_ldrate_i     (sh_ldrate_i),
        .lo_o            (a_lo),
        .hi_o            (a_hi),
        .rise_step_o     (a_rstep),
        .fall_step_o     (a_fstep),
        .rise_ival_o     (a_rival),
        .fall_ival_o     (a_fival),
        .dest_o          (a_dest),
        .nodwell_hi_o    (a_ndhi),
        .nodwell_lo_o    (a_ndlo),
        .autoclr_o       (a_auto),
        .holdclr_o       (a_hold),
        .ldrate_o        (a_ldr),
        .evt_o           (evt)
    );

    // Combine the held clear with the event-driven one-shot clear and reload.
    always_comb begin
        clr    = a_hold || (evt && a_auto);
        reload = evt && a_ldr;
    end

    drg_interval #(.INT_W(INT_W)) ival_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_ival_i (a_rival),
        .fall_ival_i (a_fival),
        .dir_up_i    (dir_up_i),
        .pause_i     (pause_i),
        .reload_i    (reload),
        .tick_o      (tick)
    );

    drg_stepper #(.ACC_W(ACC_W)) step_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lo_i         (a_lo),
        .hi_i         (a_hi),
        .rise_step_i  (a_rstep),
        .fall_step_i  (a_fstep),
        .nodwell_hi_i (a_ndhi),
        .nodwell_lo_i (a_ndlo),
        .dir_up_i     (dir_up_i),
        .tick_i       (tick),
        .clr_i        (clr),
        .acc_o        (ramp_o),
        .done_o       (done_o)
    );

    drg_router #(.ACC_W(ACC_W)) route_i (
        .dest_i       (a_dest),
        .ramp_i       (ramp_o),
        .freq_base_i  (freq_base_i),
        .phase_base_i (phase_base_i),
        .amp_base_i   (amp_base_i),
        .freq_o       (freq_o),
        .phase_o      (phase_o),
        .amp_o        (amp_o)
    );

    // R12: at most one output word departs from its base input.
    assert_single_dest_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({freq_o != freq_base_i, phase_o != phase_base_i, amp_o != amp_base_i}) <= 1);

    // R9: an event with auto-clear active leaves a zero ramp behind it.
    assert_autoclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && a_auto) |=> (ramp_o == '0));
endmodule

// File: tb/ramp_gen_top_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random segments,
// all compared each cycle against a cycle model built from the requirements.
module ramp_gen_top_tb_top;
    localparam int AW = 16;
    localparam int IW = 8;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd = 1'b0;
    logic [PW-1:0] prof = '0;
    logic dir_up = 1'b1, pause = 1'b0;
    logic [AW-1:0] s_lo = '0, s_hi = '0, s_rs = '0, s_fs = '0;
    logic [IW-1:0] s_ri = '0, s_fi = '0;
    logic [1:0] s_dest = 2'd3;
    logic s_ndh = 0, s_ndl = 0, s_auto = 0, s_hold = 0, s_ldr = 0;
    logic [AW-1:0] fb = 16'h1111, pb = 16'h2222, ab = 16'h3333;
    logic [AW-1:0] f_o, p_o, a_o, r_o;
    logic d_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    string cur_req = "R13";

    always #4 clk = ~clk;

    ramp_gen_top #(.ACC_W(AW), .INT_W(IW), .PROF_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .upd_i(upd), .prof_i(prof), .dir_up_i(dir_up),
        .pause_i(pause), .sh_lo_i(s_lo), .sh_hi_i(s_hi), .sh_rise_step_i(s_rs),
        .sh_fall_step_i(s_fs), .sh_rise_ival_i(s_ri), .sh_fall_ival_i(s_fi),
        .sh_dest_i(s_dest), .sh_nodwell_hi_i(s_ndh), .sh_nodwell_lo_i(s_ndl),
        .sh_autoclr_i(s_auto), .sh_holdclr_i(s_hold), .sh_ldrate_i(s_ldr),
        .freq_base_i(fb), .phase_base_i(pb), .amp_base_i(ab),
        .freq_o(f_o), .phase_o(p_o), .amp_o(a_o), .ramp_o(r_o), .done_o(d_o)
    );

    // Cycle model of the requirements.
    logic [AW-1:0] m_lo, m_hi, m_rs, m_fs, m_acc;
    logic [IW-1:0] m_ri, m_fi, m_cnt;
    logic [1:0] m_dest;
    logic m_ndh, m_ndl, m_auto, m_hold, m_ldr, m_evt, m_done;
    logic [PW-1:0] m_prof;

    always @(posedge clk) begin : model
        logic [IW-1:0] iv, rl;
        logic [AW:0] sum, fl;
        logic tk;
        if (!rst_n) begin
            m_lo <= '0; m_hi <= '0; m_rs <= '0; m_fs <= '0; m_ri <= '0; m_fi <= '0;
            m_dest <= 2'd3; m_ndh <= 0; m_ndl <= 0; m_auto <= 0; m_hold <= 0; m_ldr <= 0;
            m_evt <= 0; m_prof <= '0; m_cnt <= '0; m_acc <= '0; m_done <= 0;
        end else begin
            iv = dir_up ? m_ri : m_fi;
            rl = (iv == 0) ? '0 : iv - 1'b1;
            tk = 0;
            if (m_evt && m_ldr) m_cnt <= rl;
            else if (!pause) begin
                if (m_cnt == 0) begin tk = 1; m_cnt <= rl; end
                else m_cnt <= m_cnt - 1'b1;
            end
            if (m_hold || (m_evt && m_auto)) begin
                m_acc <= '0; m_done <= 0;
            end else if (tk) begin
                if (dir_up) begin
                    sum = {1'b0, m_acc} + {1'b0, m_rs};
                    if (sum >= {1'b0, m_hi}) begin
                        m_acc <= m_ndh ? m_lo : m_hi; m_done <= 1;
                    end else begin
                        m_acc <= sum[AW-1:0]; m_done <= 0;
                    end
                end else begin
                    fl = {1'b0, m_lo} + {1'b0, m_fs};
                    if ({1'b0, m_acc} <= fl) begin
                        m_acc <= m_ndl ? m_hi : m_lo; m_done <= 1;
                    end else begin
                        m_acc <= m_acc - m_fs; m_done <= 0;
                    end
                end
            end
            m_evt  <= upd || (prof != m_prof);
            m_prof <= prof;
            if (upd) begin
                m_lo <= s_lo; m_hi <= s_hi; m_rs <= s_rs; m_fs <= s_fs;
                m_ri <= s_ri; m_fi <= s_fi; m_dest <= s_dest; m_ndh <= s_ndh;
                m_ndl <= s_ndl; m_auto <= s_auto; m_hold <= s_hold; m_ldr <= s_ldr;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_word(input logic [1:0] code, input logic [1:0] dest,
                                    input logic [AW-1:0] acc, input logic [AW-1:0] base);
        return (dest == code) ? int'(acc) : int'(base);
    endfunction

    // Advance n cycles, comparing every output against the model at each negedge.
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(cur_req, r_o, m_acc);
            chk("R11", d_o, m_done);
            chk("R12", f_o, exp_word(2'd0, m_dest, m_acc, fb));
            chk("R12", p_o, exp_word(2'd1, m_dest, m_acc, pb));
            chk("R12", a_o, exp_word(2'd2, m_dest, m_acc, ab));
        end
    endtask

    task automatic strobe();
        upd = 1'b1;
        run(1);
        upd = 1'b0;
    endtask

    task automatic cfg(input int lo, input int hi, input int rs, input int fs,
                       input int ri, input int fi, input int dest);
        s_lo = AW'(lo); s_hi = AW'(hi); s_rs = AW'(rs); s_fs = AW'(fs);
        s_ri = IW'(ri); s_fi = IW'(fi); s_dest = 2'(dest);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : main
        bit seen_hi, seen_lo;
        logic [AW-1:0] held;
        void'($urandom(32'd4242));
        // R13: reset state.
        repeat (3) @(negedge clk);
        chk("R13", r_o, 0);
        chk("R13", d_o, 0);
        chk("R13", f_o, fb);
        chk("R13", a_o, ab);
        @(negedge clk) rst_n = 1'b1;

        // R1: shadow values with no strobe change nothing.
        cur_req = "R1";
        cfg(100, 1000, 50, 30, 3, 2, 0);
        run(12);
        chk("R1", r_o, 0);
        chk("R1", f_o, fb);

        // R2/R4: rising ramp with clamp at the upper bound.
        cur_req = "R2";
        strobe();
        run(80);
        chk("R2", r_o, 1000);
        chk("R11", d_o, 1);

        // R3: falling ramp clamps at the lower bound.
        cur_req = "R3";
        dir_up = 0;
        run(100);
        chk("R3", r_o, 100);

        // R5: pause holds the value.
        cur_req = "R5";
        dir_up = 1;
        run(7);
        held = r_o;
        pause = 1;
        run(20);
        chk("R5", r_o, held);
        pause = 0;
        run(5);

        // R6: no-dwell at the top never rests on the upper bound.
        cur_req = "R6";
        cfg(10, 100, 30, 7, 0, 1, 1);
        s_ndh = 1;
        strobe();
        seen_hi = 0;
        for (int i = 0; i < 40; i++) begin
            run(1);
            if (r_o == 100) seen_hi = 1;
        end
        chk("R6", seen_hi, 0);

        // R7: no-dwell at the bottom never rests on the lower bound.
        cur_req = "R7";
        s_ndh = 0; s_ndl = 1;
        strobe();
        dir_up = 0;
        seen_lo = 0;
        for (int i = 0; i < 60; i++) begin
            run(1);
            if (r_o == 10) seen_lo = 1;
        end
        chk("R7", seen_lo, 0);
        s_ndl = 0;

        // R8: held clear keeps zero.
        cur_req = "R8";
        s_hold = 1;
        strobe();
        run(15);
        chk("R8", r_o, 0);
        chk("R8", d_o, 0);
        s_hold = 0;
        strobe();
        dir_up = 1;
        run(10);

        // R9: auto-clear on a profile change alone.
        cur_req = "R9";
        s_auto = 1;
        strobe();
        run(20);
        prof = 3'd5;
        run(2);
        chk("R9", r_o, 0);
        run(10);

        // R10: load-rate restart with a long spacing.
        cur_req = "R10";
        s_ldr = 1;
        cfg(0, 60000, 3, 3, 9, 4, 2);
        strobe();
        run(4);
        prof = 3'd1;
        run(25);

        // R4: random segments against the model.
        cur_req = "R4";
        for (int seg = 0; seg < 60; seg++) begin
            int lo;
            lo = int'($urandom_range(0, 30000));
            cfg(lo, lo + 1 + int'($urandom_range(0, 30000)),
                int'($urandom_range(1, 5000)), int'($urandom_range(1, 5000)),
                int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
                int'($urandom_range(0, 3)));
            s_ndh = 1'($urandom); s_ndl = 1'($urandom);
            s_auto = 1'($urandom); s_ldr = 1'($urandom);
            s_hold = ($urandom_range(0, 7) == 0);
            strobe();
            for (int c = 0; c < 60; c++) begin
                if ($urandom_range(0, 9) == 0) dir_up = ~dir_up;
                pause = ($urandom_range(0, 5) == 0);
                if ($urandom_range(0, 29) == 0) prof = PW'($urandom);
                run(1);
            end
            pause = 0;
        end
        finish_run();
    end
endmodule